// File: doc/BRIEF.md
# External Interrupt Sense Unit

The block turns eight already-synchronised external interrupt pins into eight active-high level requests for a parent interrupt controller. Each pin has a 2-bit sense mode: low level, falling edge, rising edge or both edges. In an edge mode a detected edge sets a sticky status bit, which holds until software clears it. In low-level mode the status bit tracks the pin and cannot be cleared.

Software reaches the block through a plain 32-bit register port: a strobe, a write flag, a byte address and write data. Read data appears one cycle after the strobe. One register selects the sense modes and one holds the status bits. A status bit is cleared by writing 0 to its position, and writing 1 leaves that bit as it is. The register port is control, not a data stream, so it has no valid/ready handshake and never stalls.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every sense field is 0 (low level), every status bit is 0 and every request output is 0.
- R2: The sense-select register is at offset 0x14. Pin n's mode sits at bits [2n+1:2n], coded 0 low level, 1 falling edge, 2 rising edge, 3 both edges. A read of 0x14 returns the written value in the cycle after the strobe.
- R3: In low-level mode a pin's status bit is 1 one cycle after the pin is sampled low and 0 one cycle after it is sampled high. Writing 0 to that status bit has no effect.
- R4: In falling-edge mode a 1-to-0 pin transition sets the status bit on the next clock. A 0-to-1 transition does not set it.
- R5: In rising-edge mode a 0-to-1 pin transition sets the status bit on the next clock. A 1-to-0 transition does not set it.
- R6: In both-edge mode either transition sets the status bit.
- R7: In an edge mode a set status bit stays set until a write to offset 0x10 puts 0 in its position. Positions written with 1 keep their current value.
- R8: If a clear of a status bit and a new edge on that pin fall in the same cycle, the bit ends up set.
- R9: When a pin's sense field is rewritten with a different value, that pin's status holds for that cycle and its edge history is reloaded from the pin. A transition that happened in low-level mode is therefore never latched as an edge later.
- R10: Request output n is active high and equals status bit n.
- R11: The status register is at offset 0x10, bit n for pin n. A read returns the latched status in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 8 | Synchronised external interrupt pins |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_req | output | 8 | Active-high level requests to the parent controller |

## Verification
Two events can land in the same cycle: a software clear of a status bit and a fresh edge on the same pin. The bench provokes this by driving the pin transition and the clearing status write on the same clock edge. The bit passes only if it reads back as set afterwards, and a later plain clear then removes it. A second collision pairs a rewrite of the sense field with a stale pin history. The pin is moved while it is in level mode, the pin is then switched to an edge mode, and the bench checks that no request appears.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'd0,
    SNS_FALL = 2'd1,
    SNS_RISE = 2'd2,
    SNS_BOTH = 2'd3
  } sense_e;

  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_SENSE  = 8'h14;
endpackage

// File: rtl/eis_pin_cell.sv
module eis_pin_cell
  import eis_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin,
  input  sense_e mode,
  input  logic   reload,
  input  logic   clr,
  output logic   stat
);
  logic hist_q;
  logic rise, fall, hit;

  assign rise = pin & ~hist_q;
  assign fall = ~pin & hist_q;

  always_comb begin
    case (mode)
      SNS_FALL: hit = fall;
      SNS_RISE: hit = rise;
      SNS_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end

  // history only runs in edge modes; a mode change reloads it
  always_ff @(posedge clk) begin
    if (!rst_n)                         hist_q <= 1'b0;
    else if (reload || mode != SNS_LOW) hist_q <= pin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               stat <= 1'b0;
    else if (reload)          stat <= stat;
    else if (mode == SNS_LOW) stat <= ~pin;
    else if (hit)             stat <= 1'b1;
    else if (clr)             stat <= 1'b0;
  end

  // R3: level mode tracks the inverted pin
  a_r3_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_LOW && !reload) |=> (stat == !$past(pin)));
  // R7: sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != SNS_LOW && !reload && stat && !clr) |=> stat);
  // R7: clear honoured in edge modes when no edge arrives
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != SNS_LOW && !reload && clr && !hit) |=> !stat);
  // R8: a new edge beats a clear
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != SNS_LOW && !reload && hit && clr) |=> stat);
  // R9: status holds while the mode is rewritten
  a_r9_hold_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (stat == $past(stat)));
endmodule

// File: rtl/eis_reg_port.sv
module eis_reg_port
  import eis_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NPINS-1:0]   stat,
  output logic [2*NPINS-1:0] sense_q,
  output logic [NPINS-1:0]   reload,
  output logic [NPINS-1:0]   clr,
  output logic [DATA_W-1:0]  rdata
);
  localparam int SW = 2 * NPINS;

  logic sense_wr, stat_wr;
  logic [DATA_W-1:0] rd_next;
  logic unused_wdata;

  assign sense_wr = en & we & (addr == ADDR_W'(OFS_SENSE));
  assign stat_wr  = en & we & (addr == ADDR_W'(OFS_STATUS));
  assign unused_wdata = ^wdata[DATA_W-1:SW];

  always_ff @(posedge clk) begin
    if (!rst_n)        sense_q <= '0;
    else if (sense_wr) sense_q <= wdata[SW-1:0];
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin_ctl
    assign reload[n] = sense_wr & (wdata[2*n+1:2*n] != sense_q[2*n+1:2*n]);
    assign clr[n]    = stat_wr & ~wdata[n];
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(OFS_STATUS))     rd_next[NPINS-1:0] = stat;
    else if (addr == ADDR_W'(OFS_SENSE)) rd_next[SW-1:0]    = sense_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (en && !we)  rdata <= rd_next;
  end

  // R2: a sense write lands in the register on the next cycle
  a_r2_sense_write: assert property (@(posedge clk) disable iff (!rst_n)
    sense_wr |=> (sense_q == $past(wdata[SW-1:0])));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NPINS-1:0]  irq_req
);
  logic [2*NPINS-1:0] sense_q;
  logic [NPINS-1:0]   reload, clr, stat;

  eis_reg_port #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(reg_en), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .stat(stat), .sense_q(sense_q), .reload(reload),
    .clr(clr), .rdata(reg_rdata)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_cell
    eis_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n), .pin(pin_in[n]),
      .mode(sense_e'(sense_q[2*n+1:2*n])), .reload(reload[n]),
      .clr(clr[n]), .stat(stat[n])
    );
  end

  assign irq_req = stat;

  // R1: requests are low in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq_req == '0));
endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = 8'hFF;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_req;
  int checks = 0, errors = 0;
  bit done = 0;

  ext_irq_sense i_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_en = 0;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 req", {24'h0, irq_req}, 32'h0);
    rd(8'h10, d); chk("R1/R11 status", d, 32'h0);
    rd(8'h14, d); chk("R1 sense", d, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    pin_in[0] = 0; cyc(1);
    chk("R3/R10 low sets req", {24'h0, irq_req}, 32'h01);
    rd(8'h10, d); chk("R11 status read", d, 32'h01);
    wr(8'h10, 32'hFFFF_FFFE);
    chk("R3 clear ignored", {24'h0, irq_req}, 32'h01);
    pin_in[0] = 1; cyc(1);
    chk("R3 follows pin high", {24'h0, irq_req}, 32'h00);
  endtask

  task automatic t_modes;
    logic [31:0] d;
    wr(8'h14, 32'h0000_00E4);
    rd(8'h14, d); chk("R2 sense readback", d, 32'h0000_00E4);
    pin_in[1] = 0; cyc(1);
    chk("R4 falling latches", {31'h0, irq_req[1]}, 32'h1);
    pin_in[1] = 1; cyc(1);
    chk("R7 sticky", {31'h0, irq_req[1]}, 32'h1);
    pin_in[2] = 0; cyc(1);
    chk("R5 fall ignored", {31'h0, irq_req[2]}, 32'h0);
    pin_in[2] = 1; cyc(1);
    chk("R5 rising latches", {31'h0, irq_req[2]}, 32'h1);
    pin_in[3] = 0; cyc(1);
    chk("R6 both: fall", {31'h0, irq_req[3]}, 32'h1);
    wr(8'h10, 32'hFFFF_FFFD);
    chk("R7 clear pin1, others kept", {24'h0, irq_req}, 32'h0C);
    wr(8'h10, 32'hFFFF_FFF3);
    chk("R7 clear pins 2,3", {24'h0, irq_req}, 32'h00);
    pin_in[3] = 1; cyc(1);
    chk("R6 both: rise", {31'h0, irq_req[3]}, 32'h1);
    wr(8'h10, 32'hFFFF_FFF7);
    pin_in[1] = 1; cyc(1);
    chk("R4 rise ignored", {31'h0, irq_req[1]}, 32'h0);
  endtask

  task automatic t_collide;
    pin_in[1] = 0;
    wr(8'h10, 32'hFFFF_FFFD);
    chk("R8 edge wins over clear", {31'h0, irq_req[1]}, 32'h1);
    wr(8'h10, 32'hFFFF_FFFD);
    chk("R7 later clear", {31'h0, irq_req[1]}, 32'h0);
    pin_in[1] = 1; cyc(1);
  endtask

  task automatic t_reload;
    wr(8'h14, 32'h0000_02E4);
    pin_in[4] = 0; cyc(1);
    chk("R5 pin4 fall ignored", {31'h0, irq_req[4]}, 32'h0);
    wr(8'h14, 32'h0000_00E4);
    chk("R9 status holds on rewrite", {31'h0, irq_req[4]}, 32'h0);
    cyc(1);
    chk("R3 pin4 level low", {31'h0, irq_req[4]}, 32'h1);
    pin_in[4] = 1; cyc(1);
    chk("R3 pin4 level high", {31'h0, irq_req[4]}, 32'h0);
    wr(8'h14, 32'h0000_02E4);
    cyc(2);
    chk("R9 no false edge", {31'h0, irq_req[4]}, 32'h0);
    pin_in[4] = 0; cyc(1);
    pin_in[4] = 1; cyc(1);
    chk("R5 pin4 real rise", {31'h0, irq_req[4]}, 32'h1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    t_reset();
    t_level();
    t_modes();
    t_collide();
    t_reload();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule